// File: doc/BRIEF.md
# Command Packet Header Dispatcher

This block sits beside the sequencing microcontroller of a command processor. It turns a command header word into an entry into a handler routine. When the controller executes its wait-for-input instruction, the dispatcher arms itself. When the instruction after that one completes, the dispatcher samples the header held in general register 1 and decides what kind of packet it starts.

A register-write packet goes to one reserved handler slot. An opcode packet goes to the slot named by its opcode field. In both cases the dispatcher emits a one-cycle dispatch pulse. With that pulse it gives a new program counter read from a writable jump table, and a payload dword count for the remaining-count register. For register-write packets it also asks for register 1 to be rewritten with its type nibble cleared, so that the handler sees only the register offset. A header of any other type, or a handler index beyond the table, produces a fault pulse instead of a dispatch. A separate combinational output tells the fetch stage that an instruction word whose five top bits are zero is a no-operation.

Top module: `hdr_dispatch`

## Requirements
- R1: After reset, disp_valid, fault and hdr_wr_en are 0 and every jump table entry reads 0.
- R2: A dispatch or fault is produced only when step_done is high in a cycle after a wait_req cycle that armed the block. step_done with no pending wait_req has no effect. wait_req alone produces nothing until step_done arrives, however long that takes.
- R3: A header with bits [31:28] = 4 (register write) dispatches one cycle after the step_done cycle. The dispatch uses handler index REGWR_ID, disp_pc = table[REGWR_ID] and disp_count = bits [6:0] zero-extended.
- R4: With a register-write dispatch, hdr_wr_en pulses high with hdr_wr_data equal to the header with bits [31:28] cleared (header AND 0x0fffffff).
- R5: A header with bits [31:28] = 7 (opcode packet) dispatches with handler index bits [22:16], disp_pc = table[index] and disp_count = bits [13:0]. hdr_wr_en stays 0.
- R6: A header whose bits [31:28] are neither 4 nor 7 gives a fault pulse with fault_kind = 1 and no dispatch.
- R7: A handler index not below NUM_HANDLERS gives a fault pulse with fault_kind = 2 and no dispatch.
- R8: A table write (tbl_wr_en, tbl_wr_addr, tbl_wr_data) changes the entry that later dispatches read. Other entries keep their values.
- R9: instr_nop is 1 exactly when instr_word bits [31:27] are all zero.
- R10: disp_valid and fault last one cycle each. After a dispatch or fault the block is disarmed, so a further step_done without a new wait_req does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | Wait-for-input instruction executed; arms the block |
| step_done | input | 1 | The instruction after wait-for-input has completed |
| hdr_word | input | 32 | Current value of general register 1 |
| tbl_wr_en | input | 1 | Jump table write strobe |
| tbl_wr_addr | input | 7 | Jump table entry to write |
| tbl_wr_data | input | PC_W | Handler start address to store |
| instr_word | input | 32 | Fetched instruction word |
| instr_nop | output | 1 | Instruction word executes as no-operation |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_pc | output | PC_W | New program counter |
| disp_count | output | 14 | Payload dword count for the remaining-count register |
| hdr_wr_en | output | 1 | Rewrite register 1 |
| hdr_wr_data | output | 32 | Rewritten header value |
| fault | output | 1 | One-cycle fault pulse |
| fault_kind | output | 2 | 1 = bad packet type, 2 = handler index out of range |

## Verification
The properties check the pulse rules on every cycle. A dispatch and a fault never coincide. Each is a single cycle and follows a step_done. A header rewrite only accompanies a dispatch, its count stays in seven bits and its type nibble is clear. Whether the chosen handler address, the extracted count and the fault kind are right for a particular header, and whether table writes reach the right slot, can only be shown by the bench's scenarios. These compare against its own table model. The scenarios also cover the arming sequence: step_done with nothing pending, a long gap between arming and completion, and a repeated step_done after a dispatch.

// File: rtl/hdr_disp_pkg.sv
package hdr_disp_pkg;

    localparam int WORD_W  = 32;
    localparam int ID_W    = 7;
    localparam int CNT_W   = 14;
    localparam int RW_CNT_W = 7;

    localparam logic [3:0]        TYPE_REGWR  = 4'h4;
    localparam logic [3:0]        TYPE_OPCODE = 4'h7;
    localparam logic [WORD_W-1:0] TYPE_CLEAR_MASK = 32'h0fff_ffff;

    typedef enum logic [1:0] {
        PK_REGWR  = 2'd0,
        PK_OPCODE = 2'd1,
        PK_BAD    = 2'd2
    } pkt_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_TYPE = 2'd1,
        FLT_ID   = 2'd2
    } fault_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } disp_state_e;

    typedef struct packed {
        pkt_kind_e          kind;
        logic [ID_W-1:0]    id;
        logic [CNT_W-1:0]   count;
        logic [WORD_W-1:0]  rewritten;
    } hdr_info_t;

    function automatic pkt_kind_e classify(logic [WORD_W-1:0] h);
        if (h[31:28] == TYPE_REGWR)       return PK_REGWR;
        else if (h[31:28] == TYPE_OPCODE) return PK_OPCODE;
        else                              return PK_BAD;
    endfunction

    function automatic logic is_nop_word(logic [WORD_W-1:0] w);
        return (w[31:27] == 5'd0);
    endfunction

endpackage

// File: rtl/hdr_decode.sv
module hdr_decode
    import hdr_disp_pkg::*;
#(
    parameter logic [ID_W-1:0] REGWR_ID = 7'd127
) (
    input  logic [WORD_W-1:0] hdr,
    output hdr_info_t         info
);
    always_comb begin
        info.kind      = classify(hdr);
        info.id        = '0;
        info.count     = '0;
        info.rewritten = hdr;
        unique case (info.kind)
            PK_REGWR: begin
                info.id        = REGWR_ID;
                info.count     = CNT_W'(hdr[RW_CNT_W-1:0]);
                info.rewritten = hdr & TYPE_CLEAR_MASK;
            end
            PK_OPCODE: begin
                info.id    = hdr[22:16];
                info.count = hdr[CNT_W-1:0];
            end
            default: begin
                info.id    = '0;
                info.count = '0;
            end
        endcase
    end
endmodule

// File: rtl/handler_table.sv
module handler_table
    import hdr_disp_pkg::*;
#(
    parameter int NUM_HANDLERS = 128,
    parameter int PC_W         = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_addr,
    input  logic [PC_W-1:0] wr_data,
    input  logic [ID_W-1:0] rd_addr,
    output logic [PC_W-1:0] rd_data
);
    localparam int AW = (NUM_HANDLERS > 1) ? $clog2(NUM_HANDLERS) : 1;

    logic [PC_W-1:0] entry [NUM_HANDLERS];
    logic [AW-1:0]   rd_idx;

    for (genvar g = 0; g < NUM_HANDLERS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[g] <= '0;
            else if (wr_en && (wr_addr == ID_W'(g)))
                entry[g] <= wr_data;
        end
    end

    assign rd_idx = rd_addr[AW-1:0];

    always_comb begin
        if (32'(rd_addr) < NUM_HANDLERS)
            rd_data = entry[rd_idx];
        else
            rd_data = '0;
    end
endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
    import hdr_disp_pkg::*;
#(
    parameter int NUM_HANDLERS = 128,
    parameter int PC_W         = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wait_req,
    input  logic              step_done,
    input  hdr_info_t         info,
    input  logic [PC_W-1:0]   table_pc,
    output logic              disp_valid,
    output logic [PC_W-1:0]   disp_pc,
    output logic [CNT_W-1:0]  disp_count,
    output logic              hdr_wr_en,
    output logic [WORD_W-1:0] hdr_wr_data,
    output logic              fault,
    output fault_e            fault_kind
);
    disp_state_e state;
    logic        id_oob;

    assign id_oob = (32'(info.id) >= NUM_HANDLERS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            disp_valid  <= 1'b0;
            disp_pc     <= '0;
            disp_count  <= '0;
            hdr_wr_en   <= 1'b0;
            hdr_wr_data <= '0;
            fault       <= 1'b0;
            fault_kind  <= FLT_NONE;
        end else begin
            disp_valid <= 1'b0;
            hdr_wr_en  <= 1'b0;
            fault      <= 1'b0;
            fault_kind <= FLT_NONE;
            unique case (state)
                ST_IDLE: begin
                    if (wait_req) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (step_done) begin
                        state <= ST_IDLE;
                        if (info.kind == PK_BAD) begin
                            fault      <= 1'b1;
                            fault_kind <= FLT_TYPE;
                        end else if (id_oob) begin
                            fault      <= 1'b1;
                            fault_kind <= FLT_ID;
                        end else begin
                            disp_valid  <= 1'b1;
                            disp_pc     <= table_pc;
                            disp_count  <= info.count;
                            hdr_wr_en   <= (info.kind == PK_REGWR);
                            hdr_wr_data <= info.rewritten;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hdr_dispatch.sv
module hdr_dispatch
    import hdr_disp_pkg::*;
#(
    parameter int              NUM_HANDLERS = 128,
    parameter int              PC_W         = 16,
    parameter logic [ID_W-1:0] REGWR_ID     = 7'd127
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wait_req,
    input  logic              step_done,
    input  logic [31:0]       hdr_word,
    input  logic              tbl_wr_en,
    input  logic [6:0]        tbl_wr_addr,
    input  logic [PC_W-1:0]   tbl_wr_data,
    input  logic [31:0]       instr_word,
    output logic              instr_nop,
    output logic              disp_valid,
    output logic [PC_W-1:0]   disp_pc,
    output logic [13:0]       disp_count,
    output logic              hdr_wr_en,
    output logic [31:0]       hdr_wr_data,
    output logic              fault,
    output logic [1:0]        fault_kind
);
    hdr_info_t       info;
    logic [PC_W-1:0] table_pc;
    fault_e          fkind;

    hdr_decode #(.REGWR_ID(REGWR_ID)) u_dec (
        .hdr  (hdr_word),
        .info (info)
    );

    handler_table #(.NUM_HANDLERS(NUM_HANDLERS), .PC_W(PC_W)) u_tab (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_addr (info.id),
        .rd_data (table_pc)
    );

    disp_ctrl #(.NUM_HANDLERS(NUM_HANDLERS), .PC_W(PC_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .wait_req    (wait_req),
        .step_done   (step_done),
        .info        (info),
        .table_pc    (table_pc),
        .disp_valid  (disp_valid),
        .disp_pc     (disp_pc),
        .disp_count  (disp_count),
        .hdr_wr_en   (hdr_wr_en),
        .hdr_wr_data (hdr_wr_data),
        .fault       (fault),
        .fault_kind  (fkind)
    );

    assign fault_kind = fkind;
    assign instr_nop  = is_nop_word(instr_word);
endmodule

// File: rtl/hdr_dispatch_chk.sv
module hdr_dispatch_chk (
    input logic        clk,
    input logic        rst,
    input logic        step_done,
    input logic        disp_valid,
    input logic [13:0] disp_count,
    input logic        hdr_wr_en,
    input logic [31:0] hdr_wr_data,
    input logic        fault,
    input logic [1:0]  fault_kind
);
    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !disp_valid && !fault && !hdr_wr_en); // R1
    AST_EVENT_AFTER_STEP: assert property (@(posedge clk) disp_valid || fault |-> $past(step_done)); // R2
    AST_REGWR_COUNT: assert property (@(posedge clk) disable iff (rst) hdr_wr_en |-> disp_count < 14'd128); // R3
    AST_REWRITE_TYPE_CLEAR: assert property (@(posedge clk) disable iff (rst) hdr_wr_en |-> disp_valid && hdr_wr_data[31:28] == 4'h0); // R4
    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(disp_valid && fault)); // R6
    AST_FAULT_HAS_KIND: assert property (@(posedge clk) disable iff (rst) fault |-> fault_kind == 2'd1 || fault_kind == 2'd2); // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) disp_valid || fault |=> !disp_valid && !fault); // R10
endmodule

bind hdr_dispatch hdr_dispatch_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .step_done   (step_done),
    .disp_valid  (disp_valid),
    .disp_count  (disp_count),
    .hdr_wr_en   (hdr_wr_en),
    .hdr_wr_data (hdr_wr_data),
    .fault       (fault),
    .fault_kind  (fault_kind)
);

// File: tb/hdr_dispatch_test.sv
module hdr_dispatch_test;
    localparam int NUMH = 96;
    localparam int PCW  = 16;
    localparam logic [6:0] RWID = 7'd95;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wait_req = 1'b0, step_done = 1'b0, tbl_wr_en = 1'b0;
    logic [31:0] hdr_word = '0, instr_word = '0;
    logic [6:0]  tbl_wr_addr = '0;
    logic [PCW-1:0] tbl_wr_data = '0;
    logic instr_nop, disp_valid, hdr_wr_en, fault;
    logic [PCW-1:0] disp_pc;
    logic [13:0] disp_count;
    logic [31:0] hdr_wr_data;
    logic [1:0]  fault_kind;

    int total = 0;
    int bad = 0;
    logic [PCW-1:0] model [128];

    typedef struct {
        logic        is_fault;
        logic [PCW-1:0] pc;
        logic [13:0] cnt;
        logic        wr;
        logic [31:0] wdata;
        logic [1:0]  fk;
        string       req;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    hdr_dispatch #(.NUM_HANDLERS(NUMH), .PC_W(PCW), .REGWR_ID(RWID)) uut (
        .clk(clk), .rst(rst), .wait_req(wait_req), .step_done(step_done),
        .hdr_word(hdr_word), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data), .instr_word(instr_word), .instr_nop(instr_nop),
        .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_count(disp_count),
        .hdr_wr_en(hdr_wr_en), .hdr_wr_data(hdr_wr_data), .fault(fault),
        .fault_kind(fault_kind)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor: pops expected items as events appear
    always @(negedge clk) begin
        if (!rst && (disp_valid || fault)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2 unexpected event", {30'd0, fault, disp_valid}, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(fault == e.is_fault, {e.req, " fault"}, 32'(fault), 32'(e.is_fault));
                chk(disp_valid == !e.is_fault, {e.req, " valid"}, 32'(disp_valid), 32'(!e.is_fault));
                if (e.is_fault) begin
                    chk(fault_kind == e.fk, {e.req, " kind"}, 32'(fault_kind), 32'(e.fk));
                end else begin
                    chk(disp_pc == e.pc, {e.req, " pc"}, 32'(disp_pc), 32'(e.pc));
                    chk(disp_count == e.cnt, {e.req, " count"}, 32'(disp_count), 32'(e.cnt));
                    chk(hdr_wr_en == e.wr, {e.req, " hdr_wr_en"}, 32'(hdr_wr_en), 32'(e.wr));
                    if (e.wr)
                        chk(hdr_wr_data == e.wdata, {e.req, " hdr_wr_data"}, hdr_wr_data, e.wdata);
                end
            end
        end
    end

    task automatic twrite(input logic [6:0] a, input logic [PCW-1:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        if (32'(a) < NUMH) model[a] = d;
    endtask

    function automatic exp_t predict(input logic [31:0] h, input string req);
        exp_t e;
        e.req = req; e.is_fault = 1'b0; e.fk = 2'd0; e.wr = 1'b0; e.wdata = '0;
        e.pc = '0; e.cnt = '0;
        if (h[31:28] == 4'h4) begin
            e.pc = model[RWID]; e.cnt = {7'd0, h[6:0]};
            e.wr = 1'b1; e.wdata = {4'h0, h[27:0]};
        end else if (h[31:28] == 4'h7) begin
            if (32'(h[22:16]) >= NUMH) begin
                e.is_fault = 1'b1; e.fk = 2'd2;
            end else begin
                e.pc = model[h[22:16]]; e.cnt = h[13:0];
            end
        end else begin
            e.is_fault = 1'b1; e.fk = 2'd1;
        end
        return e;
    endfunction

    task automatic dispatch(input logic [31:0] h, input int gap, input string req);
        @(negedge clk);
        hdr_word = h; wait_req = 1'b1;
        @(negedge clk);
        wait_req = 1'b0;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            chk(!disp_valid && !fault, "R2 armed wait", {30'd0, fault, disp_valid}, 32'd0);
        end
        step_done = 1'b1;
        q.push_back(predict(h, req));
        @(negedge clk);
        step_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic quiet_check(input string req);
        @(negedge clk);
        chk(!disp_valid && !fault && !hdr_wr_en, req, {29'd0, hdr_wr_en, fault, disp_valid}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        quiet_check("R1 reset outputs");
        // R1: empty table reads zero
        dispatch(32'h7003_0002, 0, "R1 table reset");

        twrite(7'd3, 16'h0A03);
        twrite(7'd32, 16'h1234);
        twrite(RWID, 16'hBEEF);
        twrite(7'd0, 16'h0001);
        twrite(7'd94, 16'h7777);

        dispatch(32'h4000_1234, 0, "R3 R4 regwr");
        dispatch(32'h4ABC_DEFF, 0, "R3 R4 regwr max count");
        dispatch(32'h4000_0000, 0, "R3 regwr zero count");
        dispatch(32'h7003_0005, 0, "R5 opcode 3");
        dispatch(32'h7020_3FFF, 0, "R5 opcode 32 max count");
        dispatch(32'h7000_0000, 0, "R5 opcode 0");
        dispatch(32'h705E_0011, 0, "R5 opcode 94");
        dispatch(32'h705F_0001, 0, "R5 opcode regwr slot");
        dispatch(32'h1000_0000, 0, "R6 type 1");
        dispatch(32'h0000_0000, 0, "R6 type 0");
        dispatch(32'hF7FF_FFFF, 0, "R6 type 15");
        dispatch(32'h7060_0004, 0, "R7 id 96");
        dispatch(32'h707F_0004, 0, "R7 id 127");

        // R2: step_done without arming
        @(negedge clk); hdr_word = 32'h7003_0001; step_done = 1'b1;
        @(negedge clk); step_done = 1'b0;
        quiet_check("R2 unarmed step_done");
        quiet_check("R2 unarmed step_done later");

        // R2: long gap between arming and completion
        dispatch(32'h7020_0009, 6, "R2 delayed completion");

        // R10: second step_done after a dispatch is ignored
        @(negedge clk); step_done = 1'b1;
        @(negedge clk); step_done = 1'b0;
        quiet_check("R10 disarmed after dispatch");

        // R8: rewrite entry, neighbours unchanged
        twrite(7'd32, 16'h4321);
        dispatch(32'h7020_0001, 0, "R8 rewritten entry");
        dispatch(32'h7003_0001, 0, "R8 neighbour kept");
        twrite(RWID, 16'h0055);
        dispatch(32'h4000_0003, 0, "R8 regwr slot rewritten");

        // R9: no-operation detection
        instr_word = 32'h07FF_FFFF; #1;
        chk(instr_nop == 1'b1, "R9 nop top bits zero", 32'(instr_nop), 32'd1);
        instr_word = 32'h0800_0000; #1;
        chk(instr_nop == 1'b0, "R9 bit 27 set", 32'(instr_nop), 32'd0);
        instr_word = 32'hF800_0000; #1;
        chk(instr_nop == 1'b0, "R9 bit 31 set", 32'(instr_nop), 32'd0);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R2 all expected events seen", 32'(q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule